// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters from a single line. A receive-tick enable runs at sixteen times the bit rate. Each character is one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. Three samples are taken in the middle of every bit, at ticks 8, 9 and 10 of its 16-tick period, and the bit value is the majority of the three. When the three samples do not all agree, the character is marked as noisy. The line is passed through a two-flop synchronizer before any of this logic sees it.

On a multi-drop link, a node can put its receiver into standby. In standby, every character is still captured into the data output, but the data-ready flag and the interrupt are held off until a wakeup condition occurs. Two wakeup modes are available. Idle-line wakeup leaves standby once the line has been high for a whole character time. Address-mark wakeup leaves standby when a character arrives with its most significant data bit set. That waking character is reported as ready.

The control state machine has four states. S_IDLE waits for a falling edge of the line on a tick. S_START checks the start bit and returns to S_IDLE on a false start, or moves to S_DATA at the end of the start bit. S_DATA shifts in data bits and moves to S_STOP when the last data bit ends. S_STOP finishes the frame at its tick-10 decision and goes back to S_IDLE. Because the frame ends at that point, a following start edge is accepted from tick 11 of the stop bit onward.

Top module: `srx_wake`

## Requirements
- R1: After reset, rx_data is 0 and data_ready, rx_irq, frame_err, noise_err and standby are all 0.
- R2: Data bits arrive least significant bit first. With nine_bit=0, the 8 data bits appear in rx_data[7:0] and rx_data[8] is 0. With nine_bit=1, all 9 bits appear in rx_data[8:0].
- R3: Each bit is the majority of its samples at ticks 8, 9 and 10. A single flipped sample in any bit (start, data or stop) still gives the correct data and sets noise_err=1 for that character. A clean character gives noise_err=0.
- R4: If the start bit's majority is high, it is a false start. The receiver returns to idle, does not load rx_data and does not set data_ready.
- R5: A stop bit whose majority is 0 sets frame_err=1. The data is still loaded and data_ready is still set. A correct stop bit gives frame_err=0.
- R6: A frame completes at the stop bit's tick-10 decision, 154 ticks after the start edge for 8 bits and 170 ticks for 9 bits. A stop bit that lasts only 10 ticks, followed at once by the next start bit, delivers both characters correctly.
- R7: data_ready stays at 1 until a rd_ack pulse clears it. rx_irq equals data_ready AND irq_en.
- R8: A standby_set pulse sets standby to 1. While standby is 1 (and no wakeup occurs), received characters are loaded into rx_data, but data_ready stays 0.
- R9: With wake_sel=0, standby is cleared after the line has been high, with the receiver idle, for 160 ticks (nine_bit=0) or 176 ticks (nine_bit=1). The count restarts on standby_set and whenever the line goes low or a frame is in progress.
- R10: With wake_sel=1, standby is cleared only by a character whose most significant data bit (bit 7 when nine_bit=0, bit 8 when nine_bit=1) is 1. That character sets data_ready. Characters with this bit at 0, and idle time on the line, leave standby at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rt_tick | input | 1 | Receive tick enable, 16 per bit time |
| rx_in | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| standby_set | input | 1 | Pulse that puts the receiver into standby |
| wake_sel | input | 1 | Wakeup mode: 0 idle-line, 1 address-mark |
| irq_en | input | 1 | Enables rx_irq |
| rd_ack | input | 1 | Read acknowledge pulse, clears data_ready |
| rx_data | output | 9 | Last received character |
| data_ready | output | 1 | A character is waiting to be read |
| rx_irq | output | 1 | Receive interrupt request |
| frame_err | output | 1 | Stop bit of the last character was low |
| noise_err | output | 1 | Sample disagreement in the last character |
| standby | output | 1 | Receiver is in standby |

## Verification
The bench sweeps every 8-bit value and a spread of 9-bit values that reaches bit 8. A receiver with a wrong shift direction, or with the 8-bit alignment off by one, corrupts almost every one of these characters. Single-sample glitches are placed on the middle sample of each bit in turn. A design that uses only one sample gets the data wrong, and one that does not accumulate disagreement misses noise_err on that bit. False starts, low stop bits and 10-tick stop bits followed at once by a new start are all exercised. These catch a receiver that loads data on a false start, drops data on a framing error, or waits for the full stop bit and so misses the next start edge. In standby, the bench checks standby just before and just after the idle-line threshold in both character lengths. It also checks that non-address characters and long idle periods do not release address-mark standby.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_STOP  = 2'd3
    } srx_state_t;
endpackage

// File: rtl/srx_vote.sv
// Two-of-three vote over the mid-bit samples, with a disagreement flag.
module srx_vote (
    input  logic [2:0] s,
    output logic       bit_val,
    output logic       mixed
);
    always_comb begin
        bit_val = (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
        mixed   = (s != 3'b000) && (s != 3'b111);
    end
endmodule

// File: rtl/srx_idle_timer.sv
// Counts ticks of a high line while the receiver sits idle.
module srx_idle_timer #(
    parameter int OVS      = 16,
    parameter int DATA_MAX = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_high,
    input  logic restart,
    input  logic nine_bit,
    output logic full
);
    localparam int LONG_T  = OVS * (DATA_MAX + 2);
    localparam int SHORT_T = OVS * (DATA_MAX + 1);
    localparam int IW      = $clog2(LONG_T + 1);

    logic [IW-1:0] cnt;
    logic [IW-1:0] target;

    always_comb target = nine_bit ? IW'(LONG_T) : IW'(SHORT_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !line_high)
            cnt <= '0;
        else if (tick && (cnt < target))
            cnt <= cnt + 1'b1;
    end

    always_comb full = (cnt >= target);
endmodule

// File: rtl/srx_wake.sv
module srx_wake #(
    parameter int OVS      = 16,
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rt_tick,
    input  logic                rx_in,
    input  logic                nine_bit,
    input  logic                standby_set,
    input  logic                wake_sel,
    input  logic                irq_en,
    input  logic                rd_ack,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                data_ready,
    output logic                rx_irq,
    output logic                frame_err,
    output logic                noise_err,
    output logic                standby
);
    import srx_pkg::*;

    localparam int PW = $clog2(OVS + 1);
    localparam int BW = $clog2(DATA_MAX + 1);
    localparam logic [PW-1:0] PH_FIRST  = PW'(OVS / 2);
    localparam logic [PW-1:0] PH_DECIDE = PW'(OVS / 2 + 2);
    localparam logic [PW-1:0] PH_END    = PW'(OVS);

    srx_state_t          state, state_nxt;
    logic                rx_m, rx_s, rx_last;
    logic [PW-1:0]       phase, ph_nxt;
    logic [BW-1:0]       bit_cnt, nbits;
    logic [1:0]          samp;
    logic [DATA_MAX-1:0] shreg, frame_word;
    logic                noise_acc;
    logic                busy, start_edge, samp_pt, decide, bit_end, frame_done;
    logic                vote, mixed, idle_full, addr_mark;

    // line synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rx_in;
            rx_s <= rx_m;
        end
    end

    srx_vote u_vote (
        .s       ({samp, rx_s}),
        .bit_val (vote),
        .mixed   (mixed)
    );

    srx_idle_timer #(.OVS(OVS), .DATA_MAX(DATA_MAX)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rt_tick),
        .line_high (rx_s),
        .restart   (standby_set || (state != S_IDLE)),
        .nine_bit  (nine_bit),
        .full      (idle_full)
    );

    always_comb begin
        busy       = (state != S_IDLE);
        ph_nxt     = phase + 1'b1;
        start_edge = rt_tick && !busy && rx_last && !rx_s;
        samp_pt    = rt_tick && busy && (ph_nxt >= PH_FIRST) && (ph_nxt < PH_DECIDE);
        decide     = rt_tick && busy && (ph_nxt == PH_DECIDE);
        bit_end    = rt_tick && busy && (ph_nxt == PH_END);
        frame_done = (state == S_STOP) && decide;
        nbits      = nine_bit ? BW'(DATA_MAX) : BW'(DATA_MAX - 1);
        frame_word = nine_bit ? shreg : {1'b0, shreg[DATA_MAX-1:1]};
        addr_mark  = shreg[DATA_MAX-1];
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (start_edge) state_nxt = S_START;
            S_START: begin
                if (decide && vote)  state_nxt = S_IDLE;
                else if (bit_end)    state_nxt = S_DATA;
            end
            S_DATA:  if (bit_end && (bit_cnt == nbits)) state_nxt = S_STOP;
            S_STOP:  if (decide) state_nxt = S_IDLE;
        endcase
    end

    // state register and framing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= '0;
            bit_cnt   <= '0;
            samp      <= '0;
            shreg     <= '0;
            noise_acc <= 1'b0;
            rx_last   <= 1'b1;
        end else begin
            state <= state_nxt;
            if (rt_tick)
                rx_last <= rx_s;
            if (start_edge) begin
                phase     <= PW'(1);
                bit_cnt   <= '0;
                noise_acc <= 1'b0;
            end else if (rt_tick && busy) begin
                phase <= bit_end ? '0 : ph_nxt;
            end
            if (samp_pt)
                samp <= {samp[0], rx_s};
            if (decide && mixed)
                noise_acc <= 1'b1;
            if (decide && (state == S_DATA)) begin
                shreg   <= {vote, shreg[DATA_MAX-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            frame_err  <= 1'b0;
            noise_err  <= 1'b0;
            standby    <= 1'b0;
        end else begin
            if (frame_done) begin
                rx_data   <= frame_word;
                frame_err <= !vote;
                noise_err <= noise_acc || mixed;
            end
            if (frame_done && (!standby || (wake_sel && addr_mark)))
                data_ready <= 1'b1;
            else if (rd_ack)
                data_ready <= 1'b0;
            if (standby_set)
                standby <= 1'b1;
            else if (standby && !wake_sel && idle_full)
                standby <= 1'b0;
            else if (standby && wake_sel && frame_done && addr_mark)
                standby <= 1'b0;
        end
    end

    always_comb rx_irq = data_ready && irq_en;
endmodule

// File: rtl/srx_wake_chk.sv
module srx_wake_chk #(
    parameter int DW = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_ack,
    input logic                    standby_set,
    input logic                    data_ready,
    input logic                    rx_irq,
    input logic                    standby,
    input logic [DW-1:0]           rx_data,
    input srx_pkg::srx_state_t     state
);
    import srx_pkg::*;

    a_r7_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(rd_ack));

    a_r7_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> data_ready);

    a_r8_no_ready_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> !($past(standby) && standby));

    a_r8_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(standby_set));

    a_r9_wake_not_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby) |-> !$past(standby_set));

    a_r2_load_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> ($past(state) == S_STOP));

    a_r4_ready_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> ($past(state) == S_STOP));
endmodule

bind srx_wake srx_wake_chk #(.DW(DATA_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_ack      (rd_ack),
    .standby_set (standby_set),
    .data_ready  (data_ready),
    .rx_irq      (rx_irq),
    .standby     (standby),
    .rx_data     (rx_data),
    .state       (state)
);

// File: tb/srx_wake_test.sv
module srx_wake_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tk = 1'b0;
    logic       rx_in = 1'b1;
    logic       nine_bit = 1'b0;
    logic       standby_set = 1'b0;
    logic       wake_sel = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       data_ready, rx_irq, frame_err, noise_err, standby;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [8:0] last1 = '0;
    logic [8:0] last2 = '0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) tk <= ~tk;

    srx_wake uut (
        .clk(clk), .rst_n(rst_n), .rt_tick(tk), .rx_in(rx_in),
        .nine_bit(nine_bit), .standby_set(standby_set), .wake_sel(wake_sel),
        .irq_en(irq_en), .rd_ack(rd_ack), .rx_data(rx_data),
        .data_ready(data_ready), .rx_irq(rx_irq), .frame_err(frame_err),
        .noise_err(noise_err), .standby(standby)
    );

    // history of loaded values, for back-to-back frames
    always @(negedge clk) begin
        if (rx_data !== last1) begin
            last2 = last1;
            last1 = rx_data;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 190000) begin
            n_run  = n_run + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic pulse_standby();
        @(negedge clk) standby_set = 1'b1;
        @(negedge clk) standby_set = 1'b0;
    endtask

    // glitch_bit: 0 start, 1..n data, n+1 stop; -1 none. The glitch lands on tick 9.
    task automatic send(input logic [8:0] val, input int stop_len, input int glitch_bit, input logic stop_val);
        int nb;
        nb = nine_bit ? 9 : 8;
        for (int b = 0; b <= nb + 1; b++) begin
            logic base;
            int len;
            base = (b == 0) ? 1'b0 : ((b <= nb) ? val[b-1] : stop_val);
            len  = (b == nb + 1) ? stop_len : 16;
            for (int t = 1; t <= len; t++) begin
                rx_in = (b == glitch_bit && t == 9) ? ~base : base;
                ticks(1);
            end
        end
        rx_in = 1'b1;
    endtask

    initial begin
        ticks(4);
        // R1 reset state
        chk(rx_data == 9'h0 && !data_ready && !rx_irq && !frame_err && !noise_err && !standby,
            "R1 reset outputs", {rx_data, data_ready, rx_irq, frame_err, noise_err, standby}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        ticks(20);

        // R2/R7 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            irq_en = v[0];
            send(9'(v), 16, -1, 1'b1);
            ticks(4);
            chk(rx_data == {1'b0, 8'(v)} && data_ready && !frame_err && !noise_err,
                "R2 8-bit data", {rx_data, data_ready, frame_err, noise_err}, {1'b0, 8'(v), 3'b100});
            chk(rx_irq == irq_en, "R7 irq follows enable", rx_irq, irq_en);
            ticks(30);
            chk(data_ready, "R7 ready held until ack", data_ready, 1);
            pulse_ack();
            chk(!data_ready && !rx_irq, "R7 ready cleared by ack", data_ready, 0);
        end

        // R2 9-bit spread
        nine_bit = 1'b1;
        for (int k = 0; k < 64; k++) begin
            logic [8:0] v9;
            v9 = 9'(k * 8 + (k % 8));
            send(v9, 16, -1, 1'b1);
            ticks(4);
            chk(rx_data == v9 && data_ready && !frame_err && !noise_err,
                "R2 9-bit data", rx_data, v9);
            pulse_ack();
        end

        // R3 single-sample glitch in every bit position, 8-bit
        nine_bit = 1'b0;
        for (int g = 0; g <= 9; g++) begin
            send(9'h05A, 16, g, 1'b1);
            ticks(4);
            chk(rx_data == 9'h05A && noise_err && !frame_err && data_ready,
                "R3 glitch voted out, noise set", {rx_data, noise_err}, {9'h05A, 1'b1});
            pulse_ack();
        end
        send(9'h0A5, 16, -1, 1'b1);
        ticks(4);
        chk(rx_data == 9'h0A5 && !noise_err, "R3 clean frame clears noise", noise_err, 0);
        pulse_ack();

        // R4 false start
        rx_in = 1'b0;
        ticks(3);
        rx_in = 1'b1;
        ticks(40);
        chk(!data_ready && rx_data == 9'h0A5, "R4 false start ignored", {rx_data, data_ready}, {9'h0A5, 1'b0});
        send(9'h0C3, 16, -1, 1'b1);
        ticks(4);
        chk(rx_data == 9'h0C3 && data_ready, "R4 receive after false start", rx_data, 9'h0C3);
        pulse_ack();

        // R5 framing error
        send(9'h03C, 16, -1, 1'b0);
        ticks(20);
        chk(rx_data == 9'h03C && frame_err && data_ready, "R5 low stop flagged, data loaded",
            {rx_data, frame_err, data_ready}, {9'h03C, 2'b11});
        pulse_ack();
        send(9'h0E1, 16, -1, 1'b1);
        ticks(4);
        chk(!frame_err && rx_data == 9'h0E1, "R5 good stop clears frame_err", frame_err, 0);
        pulse_ack();

        // R6 short stop, back to back, both lengths
        send(9'h011, 10, -1, 1'b1);
        send(9'h0EE, 16, -1, 1'b1);
        ticks(4);
        chk(last2 == 9'h011 && last1 == 9'h0EE && !frame_err,
            "R6 8-bit 10-tick stop then next start", {last2, last1}, {9'h011, 9'h0EE});
        pulse_ack();
        nine_bit = 1'b1;
        send(9'h155, 10, -1, 1'b1);
        send(9'h0AA, 16, -1, 1'b1);
        ticks(4);
        chk(last2 == 9'h155 && last1 == 9'h0AA && !frame_err,
            "R6 9-bit 10-tick stop then next start", {last2, last1}, {9'h155, 9'h0AA});
        pulse_ack();

        // R8/R9 idle-line wakeup, 8-bit
        nine_bit = 1'b0;
        wake_sel = 1'b0;
        ticks(200);
        pulse_standby();
        chk(standby, "R8 standby set", standby, 1);
        send(9'h077, 16, -1, 1'b1);
        ticks(4);
        chk(rx_data == 9'h077 && !data_ready && standby, "R8 load without ready",
            {rx_data, data_ready, standby}, {9'h077, 2'b01});
        ticks(140);
        chk(standby, "R9 8-bit standby before threshold", standby, 1);
        ticks(20);
        chk(!standby && !data_ready, "R9 8-bit idle wake", standby, 0);

        // R9 idle-line wakeup, 9-bit, timer restarts on standby_set
        nine_bit = 1'b1;
        ticks(300);
        pulse_standby();
        ticks(165);
        chk(standby, "R9 9-bit standby before threshold", standby, 1);
        ticks(20);
        chk(!standby, "R9 9-bit idle wake", standby, 0);

        // R10 address-mark wakeup, 8-bit
        nine_bit = 1'b0;
        wake_sel = 1'b1;
        pulse_standby();
        send(9'h035, 16, -1, 1'b1);
        ticks(4);
        chk(rx_data == 9'h035 && !data_ready && standby, "R10 non-address frame stays in standby",
            {rx_data, data_ready, standby}, {9'h035, 2'b01});
        ticks(400);
        chk(standby, "R10 idle line does not wake", standby, 1);
        send(9'h0A5, 16, -1, 1'b1);
        ticks(4);
        chk(rx_data == 9'h0A5 && data_ready && !standby, "R10 8-bit address mark wakes",
            {rx_data, data_ready, standby}, {9'h0A5, 2'b10});
        pulse_ack();

        // R10 address-mark wakeup, 9-bit
        nine_bit = 1'b1;
        pulse_standby();
        send(9'h0FF, 16, -1, 1'b1);
        ticks(4);
        chk(!data_ready && standby, "R10 9-bit bit8 clear stays", {data_ready, standby}, 2'b01);
        send(9'h100, 16, -1, 1'b1);
        ticks(4);
        chk(rx_data == 9'h100 && data_ready && !standby, "R10 9-bit address mark wakes",
            {rx_data, data_ready, standby}, {9'h100, 2'b10});
        pulse_ack();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule